// File: doc/BRIEF.md
# Serial Link Power-Mode Controller

This block is a small synchronous state machine that keeps track of which power mode the data-link controller of a serial network is in. It watches a supply-good flag, a combined request from all chip reset sources, the stop and wait instruction strobes from the processor, a configuration bit that chooses what a wait instruction does, a network-activity detect and a generic wakeup request. From these it keeps one of five modes and drives four signals to the rest of the link: an encoded mode status, a clock enable, a hold-in-reset for the link datapath and a gate that blocks receive inputs.

The supply monitor, the protocol datapath and the register file are outside the block and appear only as ports. The two asynchronous wake sources pass through a synchronizer chain of `SYNC_STAGES` flops before the state machine uses them. Supply loss always takes the controller through reset mode before power off, so the datapath is held in reset before it loses power.

Top module: `linkpm_ctrl`

## Requirements
- R1: The mode output uses a 3-bit code: power off = 0, reset = 1, run = 2, wait = 3, stop = 4. No other value appears. While `rst_n` is low the mode is reset (1).
- R2: When `rst_req` is high and `supply_ok` is high, the mode is reset after the next rising clock edge, whatever the mode was before (power off, reset, run, stop or wait).
- R3: Power off is reached only from reset mode. In reset mode, a low `supply_ok` moves the controller to power off at the next edge, even while `rst_req` is high. In run, stop or wait, a low `supply_ok` moves it to reset first and to power off one edge later. Power off is kept while `supply_ok` is low, and also while `supply_ok` is high but `rst_req` is low.
- R4: In reset mode with `supply_ok` high and `rst_req` low, the mode becomes run at the next edge.
- R5: In run with no synchronized wake pending, a `stop_ins` pulse, or a `wait_ins` pulse while `wait_to_stop` is 1, moves the mode to stop at the next edge.
- R6: In run with no synchronized wake pending, a `wait_ins` pulse while `wait_to_stop` is 0 (and `stop_ins` low) moves the mode to wait at the next edge.
- R7: In stop or wait, a high `net_act` or `wake_req` returns the mode to run. With the default two synchronizer stages, an input that rises before edge k gives run after edge k+2.
- R8: An instruction strobe seen while a synchronized wake is pending leaves the controller in run.
- R9: `clk_en` is 1 in reset, run and wait, and 0 in stop and power off.
- R10: `dl_hold` is 1 in reset and power off and 0 otherwise; `rx_block` is 1 in reset, stop and power off and 0 in run and wait.
- R11: In reset mode and in power off, the instruction strobes, the wake inputs and `wait_to_stop` have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low initialisation of the controller itself |
| supply_ok | input | 1 | Supply above its minimum level |
| rst_req | input | 1 | OR of all chip reset sources |
| stop_ins | input | 1 | Stop instruction strobe, one cycle |
| wait_ins | input | 1 | Wait instruction strobe, one cycle |
| wait_to_stop | input | 1 | 1: a wait instruction enters stop; 0: it enters wait |
| net_act | input | 1 | Network activity detect, asynchronous |
| wake_req | input | 1 | Other wakeup request, asynchronous |
| mode | output | 3 | Current mode code (see R1) |
| clk_en | output | 1 | Clock enable for the link datapath |
| dl_hold | output | 1 | Holds the link datapath in reset |
| rx_block | output | 1 | Closes the receive input gate |

## Verification
The mode sequence is driven through every legal transition, and both wake sources are held so that the synchronizer delay can be counted edge by edge. A stop pulse and a wait pulse with `wait_to_stop` at each value tell the three entry decodes apart. Reset requests are raised from run, stop, wait and power off to show the override from each mode. Supply loss is applied both inside reset mode (direct power off) and in run (reset first), with and without a held reset request, and strobes are given in reset and power off to show that they are ignored there.

// File: rtl/linkpm_ctrl.sv
module linkpm_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       rst_req,
  input  logic       stop_ins,
  input  logic       wait_ins,
  input  logic       wait_to_stop,
  input  logic       net_act,
  input  logic       wake_req,
  output logic [2:0] mode,
  output logic       clk_en,
  output logic       dl_hold,
  output logic       rx_block
);

  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_RST  = 3'd1;
  localparam logic [2:0] M_RUN  = 3'd2;
  localparam logic [2:0] M_WAIT = 3'd3;
  localparam logic [2:0] M_STOP = 3'd4;
  localparam int         TOP    = SYNC_STAGES - 1;

  logic [TOP:0] na_sync, wk_sync;
  logic [2:0]   mode_q, mode_d;
  logic         wake_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      na_sync <= '0;
      wk_sync <= '0;
    end else begin
      na_sync <= {na_sync[TOP-1:0], net_act};
      wk_sync <= {wk_sync[TOP-1:0], wake_req};
    end
  end

  assign wake_s = na_sync[TOP] | wk_sync[TOP];

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_OFF:  if (supply_ok && rst_req) mode_d = M_RST;
      M_RST:  if (!supply_ok)           mode_d = M_OFF;
              else if (!rst_req)        mode_d = M_RUN;
      M_RUN:  if (rst_req || !supply_ok) mode_d = M_RST;
              else if (wake_s)           mode_d = M_RUN;
              else if (stop_ins || (wait_ins && wait_to_stop)) mode_d = M_STOP;
              else if (wait_ins)         mode_d = M_WAIT;
      M_WAIT, M_STOP:
              if (rst_req || !supply_ok) mode_d = M_RST;
              else if (wake_s)           mode_d = M_RUN;
      default: mode_d = M_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_RST;
    else        mode_q <= mode_d;
  end

  assign mode     = mode_q;
  assign clk_en   = (mode_q == M_RST) || (mode_q == M_RUN) || (mode_q == M_WAIT);
  assign dl_hold  = (mode_q == M_RST) || (mode_q == M_OFF);
  assign rx_block = (mode_q == M_RST) || (mode_q == M_OFF) || (mode_q == M_STOP);

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= M_STOP);

  p_reset_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && supply_ok) |=> (mode_q == M_RST));

  p_off_via_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RST && mode_q != M_OFF) |=> (mode_q != M_OFF));

  p_run_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RST && supply_ok && !rst_req) |=> (mode_q == M_RUN));

  p_stop_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && supply_ok && !rst_req && !wake_s &&
     (stop_ins || (wait_ins && wait_to_stop))) |=> (mode_q == M_STOP));

  p_sleep_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_STOP || mode_q == M_WAIT) && supply_ok && !rst_req && wake_s)
      |=> (mode_q == M_RUN));

  p_clk_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (mode_q == M_RUN || mode_q == M_RST));

endmodule

// File: tb/sim_linkpm_ctrl.sv
`timescale 1ns/1ps
module sim_linkpm_ctrl;

  typedef struct {
    int    m;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, rst_req = 1'b1, stop_ins = 1'b0, wait_ins = 1'b0;
  logic wait_to_stop = 1'b0, net_act = 1'b0, wake_req = 1'b0;
  logic [2:0] mode;
  logic clk_en, dl_hold, rx_block;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  localparam int OFF = 0, RST = 1, RUN = 2, WT = 3, STP = 4;

  always #2.5 clk = ~clk;

  linkpm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .rst_req(rst_req),
    .stop_ins(stop_ins), .wait_ins(wait_ins), .wait_to_stop(wait_to_stop),
    .net_act(net_act), .wake_req(wake_req), .mode(mode), .clk_en(clk_en),
    .dl_hold(dl_hold), .rx_block(rx_block)
  );

  function automatic logic [2:0] outs_for(int m);
    logic ce, dh, rb;
    ce = (m == RST) || (m == RUN) || (m == WT);
    dh = (m == RST) || (m == OFF);
    rb = (m == RST) || (m == OFF) || (m == STP);
    return {ce, dh, rb};
  endfunction

  task automatic compare(int m, string tag);
    logic [2:0] eo;
    eo = outs_for(m);
    checks++;
    if (mode !== 3'(m)) begin
      errors++;
      $display("FAIL %s (R1 mode): got %0d expected %0d", tag, mode, m);
    end
    checks++;
    if ({clk_en, dl_hold, rx_block} !== eo) begin
      errors++;
      $display("FAIL %s (R9/R10 outputs): got %b expected %b", tag,
               {clk_en, dl_hold, rx_block}, eo);
    end
  endtask

  task automatic st(bit sup, bit rr, bit sp, bit wt, bit cfg, bit wk, bit na,
                    int em, string tag);
    @(negedge clk);
    supply_ok = sup; rst_req = rr; stop_ins = sp; wait_ins = wt;
    wait_to_stop = cfg; wake_req = wk; net_act = na;
    q.push_back('{em, tag});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compare(e.m, e.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    compare(RST, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    //   sup rr sp wt cfg wk na
    st(1, 1, 0, 0, 0, 0, 0, RST, "R2 reset held");
    st(1, 1, 1, 1, 0, 0, 0, RST, "R11 strobes in reset");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R4 reset to run");
    st(1, 0, 1, 0, 0, 0, 0, STP, "R5 stop instruction");
    st(1, 0, 0, 0, 0, 0, 0, STP, "R7 stop held idle");
    st(1, 0, 0, 0, 0, 0, 1, STP, "R7 net_act sync 1");
    st(1, 0, 0, 0, 0, 0, 1, STP, "R7 net_act sync 2");
    st(1, 0, 0, 0, 0, 0, 1, RUN, "R7 net_act wakes stop");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R7 run idle");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R7 run idle");
    st(1, 0, 0, 1, 1, 0, 0, STP, "R5 wait with cfg 1");
    st(1, 0, 0, 0, 0, 1, 0, STP, "R7 wake_req sync 1");
    st(1, 0, 0, 0, 0, 1, 0, STP, "R7 wake_req sync 2");
    st(1, 0, 0, 0, 0, 1, 0, RUN, "R7 wake_req wakes stop");
    st(1, 0, 1, 0, 0, 1, 0, RUN, "R8 stop with wake pending");
    st(1, 0, 0, 1, 0, 1, 0, RUN, "R8 wait with wake pending");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R8 run idle");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R8 run idle");
    st(1, 0, 0, 1, 0, 0, 0, WT,  "R6 wait with cfg 0");
    st(1, 0, 0, 0, 1, 0, 0, WT,  "R6 wait held");
    st(1, 0, 0, 0, 0, 1, 0, WT,  "R7 wait sync 1");
    st(1, 0, 0, 0, 0, 1, 0, WT,  "R7 wait sync 2");
    st(1, 0, 0, 0, 0, 1, 0, RUN, "R7 wake_req wakes wait");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R7 run idle");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R7 run idle");
    st(1, 0, 0, 1, 0, 0, 0, WT,  "R6 wait again");
    st(1, 1, 0, 0, 0, 0, 0, RST, "R2 override from wait");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R4 reset to run");
    st(1, 0, 1, 0, 0, 0, 0, STP, "R5 stop again");
    st(1, 1, 0, 0, 0, 0, 0, RST, "R2 override from stop");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R4 reset to run");
    st(1, 1, 0, 0, 0, 0, 0, RST, "R2 override from run");
    st(0, 1, 0, 0, 0, 0, 0, OFF, "R3 supply loss in reset");
    st(0, 1, 0, 0, 0, 0, 0, OFF, "R3 off without supply");
    st(1, 0, 0, 0, 0, 0, 0, OFF, "R3 off needs reset request");
    st(1, 0, 1, 1, 1, 0, 0, OFF, "R11 strobes in off");
    st(1, 1, 0, 0, 0, 0, 0, RST, "R2 override from off");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R4 reset to run");
    st(0, 0, 0, 0, 0, 0, 0, RST, "R3 supply loss in run");
    st(0, 0, 0, 0, 0, 0, 0, OFF, "R3 off one edge later");
    st(1, 1, 0, 0, 0, 0, 0, RST, "R2 power back");
    st(1, 1, 0, 0, 0, 0, 1, RST, "R11 net_act in reset");
    st(1, 1, 0, 0, 0, 0, 1, RST, "R11 net_act in reset");
    st(1, 1, 0, 0, 0, 0, 1, RST, "R11 net_act in reset");
    st(1, 0, 0, 0, 0, 0, 0, RUN, "R4 final run");
    repeat (3) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule